// File: doc/BRIEF.md
# Parallel-In Serial-Out FIFO

This block buffers 16-bit words that arrive in parallel and sends them out one bit at a time on a single pin. A producer stores a word by pulsing an active-low write strobe. The strobe's falling edge opens the write, and the word on the data bus is stored at the rising edge. A write that opens while the buffer is full is dropped. The consumer drives a serial shift clock. Each rising edge of that clock either presents the next bit of the word being shifted, or moves the oldest stored word into the output shift register. A direction input picks least-significant-bit-first or most-significant-bit-first order, and the block samples it once for each word.

Everything runs in one clock domain. The write strobe and the shift clock are plain levels that the block samples and edge-detects. Four status flags are decoded from the occupancy count: empty, full, half-full, and a combined almost-empty/almost-full flag. The depth is a power-of-two parameter (256, 512 or 1024 in normal use, at least 8).

Top module: `piso_fifo`

## Requirements
- R1: After synchronous reset the empty flag is 1, the full, half and almost flags are 0, and the serial output is 0.
- R2: A write takes effect only at the rising edge of the write strobe that follows its falling edge. The occupancy does not change while the strobe is low. At the rising edge the data bus is stored and the occupancy goes up by one.
- R3: If the full flag is set in the cycle where the write strobe falls, that write is discarded. No data is stored, the occupancy stays the same, and the word never appears on the serial output.
- R4: Words leave in the order they were written. For each word, the shift-clock rise that loads it presents bit 0 of the chosen order, and the next 15 rises present the other bits. The 17th rise loads the next word.
- R5: A direction input of 0 sends bit 0 first and bit 15 last. A direction input of 1 sends bit 15 first and bit 0 last.
- R6: The direction is sampled when a word is loaded. Changing it partway through a word does not alter that word's bit order.
- R7: If the buffer is empty when a word would be loaded, no word is taken and the serial output is driven 0. A later shift-clock rise after a write loads the new word normally.
- R8: The empty flag is 1 exactly when the occupancy is 0. The full flag is 1 exactly when the occupancy equals the depth.
- R9: The half flag is 1 exactly when the occupancy is greater than depth/2.
- R10: The almost flag is 1 when the occupancy is from 1 up to depth/8, or when it is at least depth − depth/8. It is 0 at occupancy 0 and 0 otherwise.
- R11: When a write completes in the same cycle that a word is loaded into the shift register, the occupancy is left unchanged and both words keep their order.
- R12: The occupancy drops by one at the moment a word moves into the shift register, while that word is still being shifted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_n | input | 1 | Active-low write strobe, edge-detected |
| wr_data | input | 16 | Parallel word, captured at the strobe's rising edge |
| shift_clk | input | 1 | Serial shift clock, acts on its rising edge |
| msb_first | input | 1 | Bit order: 0 sends LSB first, 1 sends MSB first |
| ser_out | output | 1 | Serial data output |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | Occupancy equals depth |
| half | output | 1 | Occupancy above depth/2 |
| almost | output | 1 | Occupancy in the low or high band |

## Verification
The bench uses a depth of 16 and fills the buffer one word at a time. After every write it checks all four flags against thresholds it computes, and it drains the buffer the same way. This sweeps every occupancy in both directions and shows each flag's boundary exactly. The drained words use distinct bit patterns and alternate the direction input, with some of them changing the direction mid-word, so the bench can tell a wrong bit order or a late direction sample from a correct one. A write tried while the buffer is full, shift-clock rises while it is empty, and a write that lands in the same cycle as a load tell whether the full, empty and balanced-count paths are handled apart.

// File: rtl/piso_fifo_pkg.sv
package piso_fifo_pkg;

    localparam int WORD_W    = 16;
    localparam int BIT_IDX_W = $clog2(WORD_W);

    typedef logic [WORD_W-1:0]    word_t;
    typedef logic [BIT_IDX_W-1:0] bit_idx_t;

    // State of the output shift stage
    typedef struct packed {
        word_t    word;
        bit_idx_t idx;
        logic     msb_order;
        logic     live;
    } shift_st_t;

    // Decoded status flags
    typedef struct packed {
        logic empty;
        logic full;
        logic half;
        logic almost;
    } flags_t;

    localparam bit_idx_t LAST_IDX = bit_idx_t'(WORD_W - 1);

    // Select the bit presented at position idx for the chosen order
    function automatic logic pick_bit(input word_t w, input bit_idx_t idx, input logic msb_order);
        bit_idx_t pos;
        pos = msb_order ? (LAST_IDX - idx) : idx;
        return w[pos];
    endfunction

    function automatic int low_band(input int depth);
        return depth / 8;
    endfunction

    function automatic int high_band(input int depth);
        return depth - depth / 8;
    endfunction

endpackage

// File: rtl/piso_fifo_edge.sv
module piso_fifo_edge #(
    parameter logic IDLE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= IDLE;
        else     lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
    assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/piso_fifo_store.sv
module piso_fifo_store
    import piso_fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = ADDR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  word_t            wr_word,
    input  logic             rd_en,
    output word_t            rd_word,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    word_t             mem [DEPTH];
    logic [ADDR_W-1:0] wptr;
    logic [ADDR_W-1:0] rptr;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_en) wptr <= wptr + 1'b1;
            if (rd_en) rptr <= rptr + 1'b1;
            case ({wr_en, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign rd_word = mem[rptr];

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> count != CNT_FULL);
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> count != '0);
    a_r11_balanced: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en) |=> count == $past(count));
    a_r12_load_drops: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en) |=> count == $past(count) - 1'b1);
endmodule

// File: rtl/piso_fifo_flags.sv
module piso_fifo_flags
    import piso_fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count,
    output flags_t           flags
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(DEPTH / 2);
    localparam logic [CNT_W-1:0] CNT_LOW  = CNT_W'(low_band(DEPTH));
    localparam logic [CNT_W-1:0] CNT_HIGH = CNT_W'(high_band(DEPTH));

    always_comb begin
        flags.empty  = (count == '0);
        flags.full   = (count == CNT_FULL);
        flags.half   = (count > CNT_HALF);
        flags.almost = ((count != '0) && (count <= CNT_LOW)) || (count >= CNT_HIGH);
    end

    a_r8_not_both: assert property (@(posedge clk) disable iff (rst)
        !(flags.empty && flags.full));
    a_r9_full_is_half: assert property (@(posedge clk) disable iff (rst)
        flags.full |-> (flags.half && flags.almost));
endmodule

// File: rtl/piso_fifo_shifter.sv
module piso_fifo_shifter
    import piso_fifo_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    input  logic  avail,
    input  word_t word_in,
    input  logic  msb_in,
    output logic  take,
    output logic  ser
);
    shift_st_t st;
    logic      at_end;

    assign at_end = !st.live || (st.idx == LAST_IDX);
    assign take   = adv && at_end && avail;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (adv) begin
            if (at_end) begin
                if (avail) begin
                    st.word      <= word_in;
                    st.idx       <= '0;
                    st.msb_order <= msb_in;
                    st.live      <= 1'b1;
                end else begin
                    st.live <= 1'b0;
                end
            end else begin
                st.idx <= st.idx + 1'b1;
            end
        end
    end

    assign ser = st.live ? pick_bit(st.word, st.idx, st.msb_order) : 1'b0;

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (adv && at_end && !avail) |=> !ser);
    a_r6_order_held: assert property (@(posedge clk) disable iff (rst)
        (st.live && !take) |=> st.msb_order == $past(st.msb_order));
endmodule

// File: rtl/piso_fifo.sv
module piso_fifo
    import piso_fifo_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_n,
    input  logic [15:0] wr_data,
    input  logic        shift_clk,
    input  logic        msb_first,
    output logic        ser_out,
    output logic        empty,
    output logic        full,
    output logic        half,
    output logic        almost
);
    localparam int CNT_W = $clog2(DEPTH) + 1;

    logic             wr_rise, wr_fall, sh_rise, sh_fall_unused;
    logic             armed, wr_en, take;
    word_t            head_word;
    logic [CNT_W-1:0] count;
    flags_t           flags;

    piso_fifo_edge #(.IDLE(1'b1)) u_wr_edge (
        .clk(clk), .rst(rst), .lvl(wr_n), .rise(wr_rise), .fall(wr_fall)
    );

    piso_fifo_edge #(.IDLE(1'b0)) u_sh_edge (
        .clk(clk), .rst(rst), .lvl(shift_clk), .rise(sh_rise), .fall(sh_fall_unused)
    );

    // The full check happens when the strobe falls, and the commit at its rise
    always_ff @(posedge clk) begin
        if (rst)          armed <= 1'b0;
        else if (wr_fall) armed <= !flags.full;
        else if (wr_rise) armed <= 1'b0;
    end

    assign wr_en = wr_rise && armed;

    piso_fifo_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_word(wr_data),
        .rd_en(take), .rd_word(head_word),
        .count(count)
    );

    piso_fifo_flags #(.DEPTH(DEPTH)) u_flags (
        .clk(clk), .rst(rst), .count(count), .flags(flags)
    );

    piso_fifo_shifter u_shift (
        .clk(clk), .rst(rst),
        .adv(sh_rise), .avail(!flags.empty),
        .word_in(head_word), .msb_in(msb_first),
        .take(take), .ser(ser_out)
    );

    assign empty  = flags.empty;
    assign full   = flags.full;
    assign half   = flags.half;
    assign almost = flags.almost;

    a_r7_load_needs_data: assert property (@(posedge clk) disable iff (rst)
        take |-> !empty);
    a_r2_write_on_rise: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $rose(wr_n));
endmodule

// File: tb/piso_fifo_test.sv
module piso_fifo_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_n;
    logic [15:0] wr_data;
    logic        shift_clk;
    logic        msb_first;
    logic        ser_out, empty, full, half, almost;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    piso_fifo #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .wr_n(wr_n), .wr_data(wr_data),
        .shift_clk(shift_clk), .msb_first(msb_first),
        .ser_out(ser_out), .empty(empty), .full(full), .half(half), .almost(almost)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] wval(input int i);
        return 16'((i * 16'h0B53) ^ 16'hA5C3);
    endfunction

    // R8 R9 R10: flags computed from occupancy
    task automatic flags_ok(input int occ, input string req);
        logic [3:0] exp, act;
        exp[3] = (occ == 0);
        exp[2] = (occ == DEPTH);
        exp[1] = (occ > DEPTH / 2);
        exp[0] = (occ != 0 && occ <= DEPTH / 8) || (occ >= DEPTH - DEPTH / 8);
        act = {empty, full, half, almost};
        chk(act == exp, req, 32'(act), 32'(exp));
    endtask

    task automatic put(input logic [15:0] d);
        @(negedge clk) wr_n = 1'b0;
        @(negedge clk) wr_data = d; wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse(output logic b);
        @(negedge clk) shift_clk = 1'b1;
        @(negedge clk) b = ser_out; shift_clk = 1'b0;
    endtask

    task automatic take_word(input logic d, input bit flip, input int occ_after, output logic [15:0] w);
        logic b;
        msb_first = d;
        for (int j = 0; j < 16; j++) begin
            pulse(b);
            if (d) w[15 - j] = b; else w[j] = b;
            if (j == 0) flags_ok(occ_after, "R12 occupancy after load");
            if (flip && j == 5) msb_first = ~d;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] w;
        logic        b;
        logic [15:0] wa, wb, wc;

        rst = 1'b1; wr_n = 1'b1; wr_data = '0; shift_clk = 1'b0; msb_first = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        flags_ok(0, "R1 reset flags");
        chk(ser_out == 1'b0, "R1 reset ser_out", 32'(ser_out), 0);

        // R2: fall alone does not store
        @(negedge clk) wr_n = 1'b0;
        @(negedge clk);
        chk(empty == 1'b1, "R2 no change at fall", 32'(empty), 1);
        wr_data = wval(0); wr_n = 1'b1;
        @(negedge clk);
        flags_ok(1, "R2 stored at rise");

        // Fill sweep: R8 R9 R10 at every occupancy
        for (int k = 1; k < DEPTH; k++) begin
            put(wval(k));
            flags_ok(k + 1, "R8 R9 R10 fill sweep");
        end

        // R3: write while full is dropped
        put(16'hDEAD);
        flags_ok(DEPTH, "R3 blocked write occupancy");

        // Drain sweep with alternating order and mid-word flips (R4 R5 R6)
        for (int i = 0; i < DEPTH; i++) begin
            take_word(i[0], (i % 4) == 2, DEPTH - 1 - i, w);
            chk(w == wval(i), (i % 4) == 2 ? "R6 mid-word flip" : (i[0] ? "R5 msb first" : "R4 R5 lsb first"),
                32'(w), 32'(wval(i)));
        end

        // R7 and R3: nothing left, dropped word absent
        pulse(b);
        chk(b == 1'b0, "R3 R7 no extra word", 32'(b), 0);
        flags_ok(0, "R7 still empty");
        pulse(b);
        chk(b == 1'b0, "R7 idle output low", 32'(b), 0);

        // R7 recovery and R11 simultaneous write and load
        wa = 16'h3C5A; wb = 16'h8001; wc = 16'h7E13;
        put(wa);
        msb_first = 1'b0;
        pulse(b);
        w[0] = b;
        flags_ok(0, "R12 empty while shifting");
        put(wb);
        flags_ok(1, "R8 one stored");
        for (int j = 1; j < 16; j++) begin
            pulse(b);
            w[j] = b;
        end
        chk(w == wa, "R7 word after idle", 32'(w), 32'(wa));

        @(negedge clk) wr_n = 1'b0;
        @(negedge clk) wr_data = wc; wr_n = 1'b1; shift_clk = 1'b1;
        @(negedge clk) b = ser_out; shift_clk = 1'b0;
        flags_ok(1, "R11 balanced count");
        w[0] = b;
        for (int j = 1; j < 16; j++) begin
            pulse(b);
            w[j] = b;
        end
        chk(w == wb, "R11 first word intact", 32'(w), 32'(wb));
        take_word(1'b1, 1'b0, 0, w);
        chk(w == wc, "R11 second word intact", 32'(w), 32'(wc));
        pulse(b);
        chk(b == 1'b0, "R7 drained output low", 32'(b), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule